// File: doc/BRIEF.md
# Shared-Incrementer Next-Address Unit

This block produces the memory address for the coming cycle in a pipelined core. Instruction fetch, data load/store and a DMA channel all share that one memory port. The block holds two pointer registers: a program counter and a DMA address pointer. A single offset adder serves both of them, and a select bit picks which pointer is used in a given cycle. The offset is either the fixed fetch step of 2 or a branch displacement. The displacement is a signed value, sign-extended and doubled before it is added.

Jumps and data accesses do not use the pointer path. For these the address comes from the ALU sum presented at the input. A jump also writes that sum back into the program counter.

A small decoder turns a 3-bit cycle kind into five control bits: branch, select-pointer, zero, pointer-enable and DMA-select. The control bits are brought out on ports so the surrounding pipeline can observe them. The next address is a combinational function of the current pointers and inputs. The selected pointer loads that address on the rising clock edge when pointer-enable is set.

There is no data stream through this block. All pins are plain control and status signals, with no valid/ready handshake and no back-pressure.

Top module: `next_addr_unit`

## Requirements
- R1: The cycle kind is decoded as follows, with the controls listed as branch/sel/zero/en/dma. 0 fetch is 0/1/0/1/0. 1 branch is 1/1/0/1/0. 2 jump is 0/0/0/1/0. 3 reset is 0/1/1/1/0. 4 load/store is all zero. 5 DMA fetch is 0/1/0/1/1. 6 DMA reset is 0/1/1/1/1. 7 idle is all zero.
- R2: When branch is set, the pointer path address is the selected pointer plus twice the sign-extended displacement.
- R3: When branch is clear, the pointer path address is the selected pointer plus 2.
- R4: When sel is clear and zero is clear, the address equals the ALU sum input.
- R5: When zero is set, the address is 0 regardless of the other sources, and an enabled pointer becomes 0.
- R6: The selected pointer loads the address on the clock edge only when en is set. Otherwise it keeps its value.
- R7: When dma is set, the DMA pointer is both the source and the destination. When dma is clear, the program counter is both, and the unselected pointer never changes.
- R8: A load/store cycle outputs the ALU sum and leaves both pointers unchanged.
- R9: All address arithmetic wraps modulo 2^ADDR_W.
- R10: A synchronous reset clears both pointers to 0.
- R11: The idle kind 7 behaves like load/store: the address is the sum and no pointer updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kind_i | input | 3 | Cycle kind code (see R1) |
| disp_i | input | DISP_W | Signed branch displacement |
| sum_i | input | ADDR_W | ALU sum |
| addr_o | output | ADDR_W | Next memory address |
| pc_o | output | ADDR_W | Program counter |
| dma_o | output | ADDR_W | DMA pointer |
| ctl_branch_o | output | 1 | Decoded branch control |
| ctl_sel_o | output | 1 | Decoded select-pointer control |
| ctl_zero_o | output | 1 | Decoded zero control |
| ctl_en_o | output | 1 | Decoded pointer-enable control |
| ctl_dma_o | output | 1 | Decoded DMA-select control |

## Verification
The bench builds the unit with ADDR_W=8 and DISP_W=4. With these values every displacement, forward and backward, can be swept for every one of the eight cycle kinds. Pointer values also cross the 8-bit boundary within a few hundred cycles, so the wraparound of R9 is exercised in both directions. Expected addresses and pointer values come from a modular arithmetic model kept inside the bench.

// File: rtl/na_pkg.sv
package na_pkg;
  typedef enum logic [2:0] {
    K_FETCH  = 3'd0,
    K_BRANCH = 3'd1,
    K_JUMP   = 3'd2,
    K_RESET  = 3'd3,
    K_LDST   = 3'd4,
    K_DMA    = 3'd5,
    K_DMARST = 3'd6,
    K_IDLE   = 3'd7
  } cyc_kind_e;

  typedef struct packed {
    logic branch;
    logic sel;
    logic zero;
    logic en;
    logic dma;
  } na_ctl_t;

  localparam int NUM_PTR = 2;
  localparam int PTR_PC  = 0;
  localparam int PTR_DMA = 1;
endpackage

// File: rtl/na_decode.sv
module na_decode
  import na_pkg::*;
(
  input  cyc_kind_e kind_i,
  output na_ctl_t   ctl_o
);
  always_comb begin
    ctl_o = '0;
    unique case (kind_i)
      K_FETCH:  begin ctl_o.sel = 1'b1; ctl_o.en = 1'b1; end
      K_BRANCH: begin ctl_o.branch = 1'b1; ctl_o.sel = 1'b1; ctl_o.en = 1'b1; end
      K_JUMP:   begin ctl_o.en = 1'b1; end
      K_RESET:  begin ctl_o.sel = 1'b1; ctl_o.zero = 1'b1; ctl_o.en = 1'b1; end
      K_DMA:    begin ctl_o.sel = 1'b1; ctl_o.dma = 1'b1; ctl_o.en = 1'b1; end
      K_DMARST: begin
        ctl_o.sel  = 1'b1;
        ctl_o.zero = 1'b1;
        ctl_o.dma  = 1'b1;
        ctl_o.en   = 1'b1;
      end
      default:  ctl_o = '0;
    endcase
  end

  always_comb begin
    if (ctl_o.zero) assert_zero_implies_sel_R1: assert (ctl_o.sel && ctl_o.en);
    if (ctl_o.branch) assert_branch_not_dma_R1: assert (!ctl_o.dma && !ctl_o.zero);
  end
endmodule

// File: rtl/na_offset.sv
module na_offset #(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 8,
  parameter int SHIFT  = 1,
  parameter int STEP   = 2
) (
  input  logic              branch_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W-1:0] incr_o
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] off;

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    end else begin : g_trunc
      assign disp_ext = disp_i[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    off    = branch_i ? (disp_ext << SHIFT) : ADDR_W'(STEP);
    incr_o = base_i + off;
  end
endmodule

// File: rtl/na_ptr_bank.sv
module na_ptr_bank
  import na_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            en_i,
  input  logic                            dma_i,
  input  logic [ADDR_W-1:0]               load_i,
  output logic [ADDR_W-1:0]               cur_o,
  output logic [NUM_PTR-1:0][ADDR_W-1:0]  ptr_o
);
  logic [NUM_PTR-1:0] wr;

  generate
    for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
      assign wr[i] = en_i && ((i == PTR_DMA) ? dma_i : !dma_i);
      always_ff @(posedge clk) begin
        if (rst)        ptr_o[i] <= '0;
        else if (wr[i]) ptr_o[i] <= load_i;
      end
    end
  endgenerate

  assign cur_o = dma_i ? ptr_o[PTR_DMA] : ptr_o[PTR_PC];

  assert_reset_R10: assert property (@(posedge clk)
    rst |=> (ptr_o[PTR_PC] == '0 && ptr_o[PTR_DMA] == '0));
  assert_pc_load_R6: assert property (@(posedge clk) disable iff (rst)
    (en_i && !dma_i) |=> ptr_o[PTR_PC] == $past(load_i));
  assert_dma_load_R7: assert property (@(posedge clk) disable iff (rst)
    (en_i && dma_i) |=> ptr_o[PTR_DMA] == $past(load_i));
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> ($stable(ptr_o[PTR_PC]) && $stable(ptr_o[PTR_DMA])));
endmodule

// File: rtl/next_addr_unit.sv
module next_addr_unit
  import na_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        kind_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [ADDR_W-1:0] sum_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] dma_o,
  output logic              ctl_branch_o,
  output logic              ctl_sel_o,
  output logic              ctl_zero_o,
  output logic              ctl_en_o,
  output logic              ctl_dma_o
);
  na_ctl_t                          ctl;
  logic [ADDR_W-1:0]                cur;
  logic [ADDR_W-1:0]                incr;
  logic [NUM_PTR-1:0][ADDR_W-1:0]   ptrs;

  na_decode u_dec (
    .kind_i (cyc_kind_e'(kind_i)),
    .ctl_o  (ctl)
  );

  na_offset #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .SHIFT(1), .STEP(2)) u_off (
    .branch_i (ctl.branch),
    .disp_i   (disp_i),
    .base_i   (cur),
    .incr_o   (incr)
  );

  always_comb begin
    if (ctl.zero)     addr_o = '0;
    else if (ctl.sel) addr_o = incr;
    else              addr_o = sum_i;
  end

  na_ptr_bank #(.ADDR_W(ADDR_W)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .en_i   (ctl.en),
    .dma_i  (ctl.dma),
    .load_i (addr_o),
    .cur_o  (cur),
    .ptr_o  (ptrs)
  );

  assign pc_o         = ptrs[PTR_PC];
  assign dma_o        = ptrs[PTR_DMA];
  assign ctl_branch_o = ctl.branch;
  assign ctl_sel_o    = ctl.sel;
  assign ctl_zero_o   = ctl.zero;
  assign ctl_en_o     = ctl.en;
  assign ctl_dma_o    = ctl.dma;

  assert_ldst_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (kind_i == 3'd4) |=> ($stable(pc_o) && $stable(dma_o)));
  assert_zero_ptr_R5: assert property (@(posedge clk) disable iff (rst)
    (kind_i == 3'd3) |=> (pc_o == '0 && $stable(dma_o)));
  assert_jump_pc_R4: assert property (@(posedge clk) disable iff (rst)
    (kind_i == 3'd2) |=> (pc_o == $past(sum_i) && $stable(dma_o)));
  assert_dma_only_R7: assert property (@(posedge clk) disable iff (rst)
    (kind_i == 3'd5) |=> $stable(pc_o));
endmodule

// File: tb/next_addr_unit_tb_top.sv
module next_addr_unit_tb_top;
  localparam int AW = 8;
  localparam int DW = 4;
  localparam int MOD = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    kind = 3'd4;
  logic [DW-1:0] disp = '0;
  logic [AW-1:0] sum = '0;
  logic [AW-1:0] addr, pc, dmap;
  logic          cb, cs, cz, ce, cd;

  int n_chk = 0;
  int n_fail = 0;
  int pc_m = 0;
  int dma_m = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  next_addr_unit #(.ADDR_W(AW), .DISP_W(DW)) dut_i (
    .clk(clk), .rst(rst), .kind_i(kind), .disp_i(disp), .sum_i(sum),
    .addr_o(addr), .pc_o(pc), .dma_o(dmap),
    .ctl_branch_o(cb), .ctl_sel_o(cs), .ctl_zero_o(cz), .ctl_en_o(ce), .ctl_dma_o(cd)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_ctl(input int k);
    case (k)
      0: return 5'b01010;
      1: return 5'b11010;
      2: return 5'b00010;
      3: return 5'b01110;
      5: return 5'b01011;
      6: return 5'b01111;
      default: return 5'b00000;
    endcase
  endfunction

  task automatic step(input int k, input int d, input int s);
    int ds, base, ea, off;
    logic [4:0] ec;
    string tag;
    @(negedge clk);
    kind = 3'(k); disp = DW'(d); sum = AW'(s);
    #1;
    ec = exp_ctl(k);
    check({cb, cs, cz, ce, cd} == ec, "R1 decode", int'({cb, cs, cz, ce, cd}), int'(ec));
    ds   = (d >= (1 << (DW - 1))) ? d - (1 << DW) : d;
    base = ec[0] ? dma_m : pc_m;
    off  = ec[4] ? 2 * ds : 2;
    if (ec[2])      begin ea = 0; tag = "R5 zero"; end
    else if (ec[3]) begin
      ea = ((base + off) % MOD + MOD) % MOD;
      tag = ec[4] ? "R2/R9 branch" : (ec[0] ? "R7/R3 dma step" : "R3/R9 step");
    end
    else begin
      ea = s;
      tag = (k == 2) ? "R4 sum" : ((k == 4) ? "R8 ldst addr" : "R11 idle addr");
    end
    check(addr == AW'(ea), tag, int'(addr), ea);
    if (ec[1]) begin
      if (ec[0]) dma_m = ea; else pc_m = ea;
    end
    @(posedge clk); #1;
    check(pc == AW'(pc_m), "R6/R7 pc", int'(pc), pc_m);
    check(dmap == AW'(dma_m), "R6/R7/R8 dma", int'(dmap), dma_m);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check(pc == 0, "R10 reset pc", int'(pc), 0);
    check(dmap == 0, "R10 reset dma", int'(dmap), 0);
    @(negedge clk); rst = 1'b0;
    for (int k = 0; k < 8; k++)
      for (int d = 0; d < (1 << DW); d++)
        for (int s = 0; s < 3; s++) begin
          step(k, d, (k * 37 + d * 11 + s * 53) % MOD);
          if (k == 4 || k == 2) step(1, d, 0);
          if (k == 6) step(5, d, 0);
        end
    // long forward walk for wrap on both pointers (R9)
    for (int i = 0; i < 140; i++) begin
      step(0, 0, 0);
      step(5, 0, 0);
    end
    for (int i = 0; i < 40; i++) step(1, 8, 0);
    // mid-run reset (R10)
    @(negedge clk); rst = 1'b1; kind = 3'd0;
    @(posedge clk); #1;
    check(pc == 0, "R10 sync reset pc", int'(pc), 0);
    check(dmap == 0, "R10 sync reset dma", int'(dmap), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule